// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Adjustment

This block keeps a free-running time-of-day count for precision time protocol work. The time is a 55-bit unsigned count in units of 2^-8 ns, which matches bits 62:8 of an IEEE 1588 correction field with the bottom eight bits taken as zero. A 32-bit fraction sits below the time, so an increment with a resolution of 2^-40 ns can be added on every clock edge. At reset the increment is about 1.551515 ns per cycle.

Software or a servo sends requests on an adjust port. A request is signalled by a change of level on a toggle line. Each request carries a kind code and a 32-bit word, and the block can step the time, replace the increment, or trim the increment. A second toggle line marks an external 55-bit time as valid. If load-enable is high when that toggle arrives, the internal time is replaced with the external value. The block takes a snapshot of the low 32 time bits every 16 cycles. It flips a sync-out line when it takes a snapshot and shows the value two cycles later.

Top module: `ptpTimer`

## Requirements
- R1: After reset, sampleOut, syncOut and sampleEdge are 0, the time and its fraction are 0, and the increment is 397 integer units plus fraction 0x30164841 (about 1.551515 ns).
- R2: On every clock edge the 87-bit value {time, fraction} grows by the 42-bit increment {10 integer bits in 2^-8 ns, 32 fraction bits in 2^-40 ns}. A carry out of the fraction enters the time, and the time wraps modulo 2^55.
- R3: An adjust request is taken in the cycle in which adjValidTgl differs from its value in the previous cycle, so both rising and falling edges count. A steady level causes no request, whatever adjKind and adjWord carry. adjValidTgl must be 0 during reset.
- R4: Kind 0 (adjKind = 2'd0) sign-extends adjWord[17:0] and adds it to the time, in 2^-8 ns units, on top of the normal increment for that cycle. The result wraps modulo 2^55 and adjWord[31:18] are ignored.
- R5: Kind 1 replaces the increment with adjWord[9:0] integer units and a zero fraction. adjWord[31:10] are ignored. The new increment is used from the following cycle.
- R6: Kind 2 adds adjWord as a signed 32-bit value in 2^-40 ns units to the 42-bit increment, which wraps. The new increment is used from the following cycle.
- R7: Kind 3 changes neither the time nor the increment.
- R8: A change of level on syncTgl with loadEnable high sets the time to extTime and clears the fraction. No increment is added in that cycle. With loadEnable low the toggle has no effect. syncTgl must be 0 during reset.
- R9: If a load and a kind 0 step fall in the same cycle, the load wins and the step is discarded. A kind 1 or kind 2 request in that cycle still updates the increment.
- R10: sampleEdge is high for one cycle in every 16, starting with the 16th cycle after reset. At the edge that ends that cycle, syncOut toggles and the low 32 bits of the time held during that cycle are captured.
- R11: sampleOut takes the captured value two clock edges after the syncOut toggle and holds it until the next capture has passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adjValidTgl | input | 1 | Adjust request toggle |
| adjKind | input | 2 | Adjust kind: 0 step time, 1 set increment, 2 trim increment, 3 none |
| adjWord | input | 32 | Adjust value |
| syncTgl | input | 1 | External time valid toggle |
| loadEnable | input | 1 | Allows a load when syncTgl toggles |
| extTime | input | 55 | External time, units of 2^-8 ns |
| sampleOut | output | 32 | Low 32 bits of the latest time snapshot |
| syncOut | output | 1 | Toggles at each snapshot |
| sampleEdge | output | 1 | High in the cycle in which the snapshot is taken |

## Verification
A toggle seen on adjValidTgl or syncTgl before a clock edge acts on the time and increment at that edge. Those registers can only be seen through the snapshots, so their effect appears in the sampleOut value after the next capture. A capture happens at the edge that ends a sampleEdge cycle. syncOut changes at that edge, and sampleOut changes two edges later. The bench keeps a reference model that advances once per clock from the stated rules. It drives inputs and compares all three outputs on the falling edge, half a period away from any register update, so each result is compared in the cycle it is due.

// File: rtl/ptpTimerPkg.sv
package ptpTimerPkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic load;     // replace time with external value
    logic step;     // add signed offset to time
    logic incLoad;  // replace increment
    logic incTrim;  // add signed fine value to increment
    logic sample;   // take a snapshot this cycle
  } tmrStrobeT;
endpackage

// File: rtl/ptpTimerCtrl.sv
module ptpTimerCtrl
  import ptpTimerPkg::*;
#(
  parameter int SAMPLE_PERIOD = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      adjValidTgl,
  input  logic [1:0] adjKind,
  input  logic      syncTgl,
  input  logic      loadEnable,
  output tmrStrobeT strobes
);
  localparam int CNT_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_PERIOD - 1);

  logic prevAdj, prevSync;
  logic [CNT_W-1:0] sampleCnt;
  logic adjEdge, syncEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAdj   <= 1'b0;
      prevSync  <= 1'b0;
      sampleCnt <= '0;
    end else begin
      prevAdj  <= adjValidTgl;
      prevSync <= syncTgl;
      if (sampleCnt == CNT_LAST) sampleCnt <= '0;
      else                       sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_comb begin
    adjEdge         = adjValidTgl ^ prevAdj;
    syncEdge        = syncTgl ^ prevSync;
    strobes.load    = syncEdge & loadEnable;
    strobes.step    = adjEdge & (adjKind == 2'd0) & ~strobes.load;
    strobes.incLoad = adjEdge & (adjKind == 2'd1);
    strobes.incTrim = adjEdge & (adjKind == 2'd2);
    strobes.sample  = (sampleCnt == CNT_LAST);
  end
endmodule

// File: rtl/ptpTimerDatapath.sv
module ptpTimerDatapath
  import ptpTimerPkg::*;
#(
  parameter int TIME_W     = 55,
  parameter int FRAC_W     = 32,
  parameter int INC_INT_W  = 10,
  parameter int STEP_W     = 18,
  parameter int ADJ_W      = 32,
  parameter int OUT_W      = 32,
  parameter int OUT_DELAY  = 2,
  parameter logic [INC_INT_W-1:0] RESET_INC_INT  = 10'd397,
  parameter logic [FRAC_W-1:0]    RESET_INC_FRAC = 32'h30164841
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobeT         strobes,
  input  logic [ADJ_W-1:0]  adjWord,
  input  logic [TIME_W-1:0] extTime,
  output logic [TIME_W-1:0] timeNow,
  output logic [INC_INT_W+FRAC_W-1:0] incNow,
  output logic [OUT_W-1:0]  sampleOut,
  output logic              syncOut
);
  localparam int ACC_W = TIME_W + FRAC_W;
  localparam int INC_W = INC_INT_W + FRAC_W;

  logic [ACC_W-1:0] acc, incExt, stepVal;
  logic [INC_W-1:0] incReg, trimVal;
  logic [OUT_W-1:0] stage [OUT_DELAY+1];

  always_comb begin
    incExt  = ACC_W'(incReg);
    stepVal = {{(TIME_W-STEP_W){adjWord[STEP_W-1]}}, adjWord[STEP_W-1:0], {FRAC_W{1'b0}}};
    trimVal = {{(INC_W-ADJ_W){adjWord[ADJ_W-1]}}, adjWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      incReg <= {RESET_INC_INT, RESET_INC_FRAC};
    end else begin
      if (strobes.load)      acc <= {extTime, {FRAC_W{1'b0}}};
      else if (strobes.step) acc <= acc + incExt + stepVal;
      else                   acc <= acc + incExt;
      if (strobes.incLoad)      incReg <= {adjWord[INC_INT_W-1:0], {FRAC_W{1'b0}}};
      else if (strobes.incTrim) incReg <= incReg + trimVal;
    end
  end

  // snapshot capture and delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage[0] <= '0;
      syncOut  <= 1'b0;
    end else if (strobes.sample) begin
      stage[0] <= acc[FRAC_W +: OUT_W];
      syncOut  <= ~syncOut;
    end
  end

  for (genvar i = 1; i <= OUT_DELAY; i++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign timeNow   = acc[ACC_W-1:FRAC_W];
  assign incNow    = incReg;
  assign sampleOut = stage[OUT_DELAY];
endmodule

// File: rtl/ptpTimer.sv
module ptpTimer
  import ptpTimerPkg::*;
#(
  parameter int TIME_W        = 55,
  parameter int FRAC_W        = 32,
  parameter int INC_INT_W     = 10,
  parameter int STEP_W        = 18,
  parameter int ADJ_W         = 32,
  parameter int OUT_W         = 32,
  parameter int OUT_DELAY     = 2,
  parameter int SAMPLE_PERIOD = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adjValidTgl,
  input  logic [1:0]        adjKind,
  input  logic [ADJ_W-1:0]  adjWord,
  input  logic              syncTgl,
  input  logic              loadEnable,
  input  logic [TIME_W-1:0] extTime,
  output logic [OUT_W-1:0]  sampleOut,
  output logic              syncOut,
  output logic              sampleEdge
);
  localparam int INC_W = INC_INT_W + FRAC_W;

  tmrStrobeT         strobes;
  logic [TIME_W-1:0] timeNow;
  logic [INC_W-1:0]  incNow;

  ptpTimerCtrl #(.SAMPLE_PERIOD(SAMPLE_PERIOD)) ctrl (
    .clk(clk), .rstN(rstN), .adjValidTgl(adjValidTgl), .adjKind(adjKind),
    .syncTgl(syncTgl), .loadEnable(loadEnable), .strobes(strobes)
  );

  ptpTimerDatapath #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_INT_W(INC_INT_W), .STEP_W(STEP_W),
    .ADJ_W(ADJ_W), .OUT_W(OUT_W), .OUT_DELAY(OUT_DELAY)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adjWord(adjWord),
    .extTime(extTime), .timeNow(timeNow), .incNow(incNow),
    .sampleOut(sampleOut), .syncOut(syncOut)
  );

  assign sampleEdge = strobes.sample;
endmodule

// File: rtl/ptpTimerChk.sv
module ptpTimerChk
  import ptpTimerPkg::*;
#(
  parameter int TIME_W    = 55,
  parameter int FRAC_W    = 32,
  parameter int INC_INT_W = 10,
  parameter int ADJ_W     = 32,
  parameter int OUT_W     = 32,
  parameter int OUT_DELAY = 2
) (
  input logic              clk,
  input logic              rstN,
  input tmrStrobeT         strobes,
  input logic [ADJ_W-1:0]  adjWord,
  input logic [TIME_W-1:0] extTime,
  input logic [TIME_W-1:0] timeNow,
  input logic [INC_INT_W+FRAC_W-1:0] incNow,
  input logic [OUT_W-1:0]  sampleOut,
  input logic              syncOut,
  input logic              sampleEdge
);
  localparam int INC_W = INC_INT_W + FRAC_W;
  logic [INC_W-1:0] trimExt;
  assign trimExt = {{(INC_W-ADJ_W){adjWord[ADJ_W-1]}}, adjWord};

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> timeNow == $past(extTime));
  // R5
  inc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incLoad |=> incNow == {$past(adjWord[INC_INT_W-1:0]), {FRAC_W{1'b0}}});
  // R6
  inc_trim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incTrim && !strobes.incLoad) |=> incNow == $past(incNow) + $past(trimExt));
  // R7
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incTrim && !strobes.incLoad) |=> incNow == $past(incNow));
  // R10
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEdge |=> !sampleEdge);
  // R10
  sync_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEdge |=> syncOut != $past(syncOut));
  // R10
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEdge |=> syncOut == $past(syncOut));
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleEdge, OUT_DELAY + 1) |-> $stable(sampleOut));
endmodule

bind ptpTimer ptpTimerChk #(
  .TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_INT_W(INC_INT_W),
  .ADJ_W(ADJ_W), .OUT_W(OUT_W), .OUT_DELAY(OUT_DELAY)
) chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .adjWord(adjWord),
  .extTime(extTime), .timeNow(timeNow), .incNow(incNow),
  .sampleOut(sampleOut), .syncOut(syncOut), .sampleEdge(sampleEdge)
);

// File: tb/ptpTimer_test.sv
module ptpTimer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, adjValidTgl, syncTgl, loadEnable;
  logic [1:0]  adjKind;
  logic [31:0] adjWord;
  logic [54:0] extTime;
  logic [31:0] sampleOut;
  logic        syncOut, sampleEdge;

  ptpTimer uut (
    .clk(clk), .rstN(rstN), .adjValidTgl(adjValidTgl), .adjKind(adjKind),
    .adjWord(adjWord), .syncTgl(syncTgl), .loadEnable(loadEnable),
    .extTime(extTime), .sampleOut(sampleOut), .syncOut(syncOut),
    .sampleEdge(sampleEdge)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  logic [86:0] mAcc;
  logic [41:0] mInc;
  logic [31:0] mStg [3];
  int          mCnt;
  logic        mSync, mPrevA, mPrevS;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [86:0] stepOf(logic [31:0] w);
    return {{37{w[17]}}, w[17:0], 32'b0};
  endfunction

  function automatic logic [41:0] trimOf(logic [31:0] w);
    return {{10{w[31]}}, w};
  endfunction

  task automatic modelReset();
    mAcc = '0; mInc = {10'd397, 32'h30164841};
    mStg[0] = '0; mStg[1] = '0; mStg[2] = '0;
    mCnt = 0; mSync = 0; mPrevA = 0; mPrevS = 0;
  endtask

  // advance model by one edge with current inputs, then compare at negedge
  task automatic step();
    logic aE, sE, ld;
    logic [86:0] nAcc;
    logic [41:0] nInc;
    aE = adjValidTgl ^ mPrevA;
    sE = syncTgl ^ mPrevS;
    ld = sE & loadEnable;
    if (ld)                         nAcc = {extTime, 32'b0};
    else if (aE && adjKind == 2'd0) nAcc = mAcc + {45'b0, mInc} + stepOf(adjWord);
    else                            nAcc = mAcc + {45'b0, mInc};
    nInc = mInc;
    if (aE && adjKind == 2'd1)      nInc = {adjWord[9:0], 32'b0};
    else if (aE && adjKind == 2'd2) nInc = mInc + trimOf(adjWord);
    mStg[2] = mStg[1];
    mStg[1] = mStg[0];
    if (mCnt == 15) begin
      mStg[0] = mAcc[63:32];
      mSync = ~mSync;
    end
    mCnt = (mCnt + 1) % 16;
    mAcc = nAcc; mInc = nInc;
    mPrevA = adjValidTgl; mPrevS = syncTgl;
    @(posedge clk);
    @(negedge clk);
    chk("R10 edge", {63'b0, sampleEdge}, {63'b0, mCnt == 15});
    chk("R10 sync", {63'b0, syncOut}, {63'b0, mSync});
    chk({"R11 ", curTag}, {32'b0, sampleOut}, {32'b0, mStg[2]});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doAdj(logic [1:0] k, logic [31:0] w);
    adjKind = k; adjWord = w; adjValidTgl = ~adjValidTgl;
    step();
  endtask

  task automatic doSync(logic le, logic [54:0] t);
    loadEnable = le; extTime = t; syncTgl = ~syncTgl;
    step();
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r64;
    void'($urandom(32'd20240611));
    rstN = 0; adjValidTgl = 0; syncTgl = 0; loadEnable = 0;
    adjKind = 0; adjWord = 0; extTime = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    // R1 reset state
    chk("R1 out", {32'b0, sampleOut}, 64'd0);
    chk("R1 sync", {63'b0, syncOut}, 64'd0);
    chk("R1 edge", {63'b0, sampleEdge}, 64'd0);
    curTag = "R1 R2 default increment"; idle(40);
    // R5 set increment, upper word bits must be ignored
    curTag = "R5"; doAdj(2'd1, 32'hFFFF_F100); idle(40);
    // R6 trim by a negative fine value, via falling toggle (R3)
    curTag = "R6 R3"; doAdj(2'd2, 32'h8000_0001); idle(40);
    curTag = "R6"; doAdj(2'd2, 32'h7FFF_FFFF); idle(40);
    // R4 negative step, then wrap below zero
    curTag = "R4"; doAdj(2'd0, 32'hFFFE_0000); idle(20);
    doSync(1'b1, 55'd0); doAdj(2'd0, 32'h0003_FFFF); idle(40);
    // R7 kind 3 ignored, R3 steady level ignored with changing data
    curTag = "R7"; doAdj(2'd3, 32'hFFFF_FFFF); idle(20);
    curTag = "R3"; adjKind = 2'd0; adjWord = 32'h0001_0000; idle(20);
    // R8 sync without and with load enable
    curTag = "R8"; doSync(1'b0, 55'h7F_FFFF_FFFF_FFFF); idle(20);
    doSync(1'b1, 55'h12_3456_789A_BCDE); idle(40);
    // R9 load and step in same cycle; load and increment set in same cycle
    curTag = "R9";
    adjKind = 2'd0; adjWord = 32'h0001_FFFF; adjValidTgl = ~adjValidTgl;
    loadEnable = 1; extTime = 55'h00_0000_1000_0000; syncTgl = ~syncTgl; step();
    idle(20);
    adjKind = 2'd1; adjWord = 32'h0000_0200; adjValidTgl = ~adjValidTgl;
    extTime = 55'h55_5555_5555_5555; syncTgl = ~syncTgl; step();
    idle(40);
    // R2 random mix
    curTag = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      r64 = {$urandom, $urandom};
      if (r == 0) doAdj(2'($urandom % 4), $urandom);
      else if (r == 1) doSync(1'($urandom % 2), r64[54:0]);
      else if (r == 2) begin
        adjKind = 2'($urandom % 4); adjWord = $urandom; adjValidTgl = ~adjValidTgl;
        loadEnable = 1'($urandom % 2); extTime = r64[54:0]; syncTgl = ~syncTgl;
        step();
      end else begin
        adjKind = 2'($urandom % 4); adjWord = $urandom;
        loadEnable = 1'($urandom % 2); extTime = r64[54:0];
        step();
      end
    end
    idle(20);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule